// File: doc/BRIEF.md
# Indirect CSR Access Window

This block decodes machine-level CSR accesses for indirect register access. A select register holds a number that chooses one entry of a small target bank. Five alias CSR numbers then act as windows onto that entry: every read, write, set or clear on a window lands in the target picked by the select value as it stands at the moment of the access. The targets are plain XLEN-wide storage held inside the block. A one-hot write strobe tells the surrounding logic which target changed.

Each request is a single-cycle pulse carrying the CSR address, the operation, the write data and the current privilege level. One cycle later the block answers with a response. The response says whether the address belongs to this block, whether the access must raise an illegal-instruction exception, and what the old value was. Addresses this block does not own, including 0x354 which sits between the windows, are left to other decoders. Trap entry and pipeline control belong to the surrounding core.

Top module: `csr_indirect_window`

## Requirements
- R1: After reset the select register and every target read as zero, and no response or write strobe is presented.
- R2: The select register sits at address 0x350 and holds a full XLEN-bit value. Write replaces it, set ORs in the operand and clear removes the operand bits. A read returns the value held before the access.
- R3: Addresses 0x351, 0x352, 0x353, 0x355 and 0x356 are windows 1 to 5. With an implemented select value S, window w reads and updates target (S - SEL_BASE)*5 + (w - 1). The response data is the target's value before the access.
- R4: On a target or on the select register, operation code 0 reads, 1 writes the operand, 2 sets the operand bits and 3 clears them. A set or clear with a zero operand changes nothing and raises no write strobe. A plain write of zero does raise one.
- R5: Each target update raises exactly the strobe bit for that target, in the response cycle. Reads, illegal accesses and accesses to the select register raise none.
- R6: A window access with a select value outside SEL_BASE to SEL_BASE+SEL_COUNT-1 responds as owned and illegal, with zero data. It changes no state. A select value equal to a CSR number gets no special treatment.
- R7: Any access to 0x350 or a window at a privilege level other than machine (code 3) responds as owned and illegal, with zero data, and changes no state.
- R8: Any other address, including 0x354, 0x34F and 0x357, responds as not owned and not illegal, with zero data and no strobe, and changes no state.
- R9: Every request produces a response exactly one cycle later. Requests may arrive back to back. A select update is already in force for a window access in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_valid | input | 1 | Request pulse, one cycle per access |
| csr_addr | input | 12 | CSR number of the access |
| csr_op | input | 2 | 0 read, 1 write, 2 set, 3 clear |
| csr_wdata | input | XLEN | Write, set or clear operand |
| priv_lvl | input | 2 | Current privilege level, 3 is machine |
| rsp_valid | output | 1 | Response present, one cycle after a request |
| rsp_hit | output | 1 | Address is the select register or a window |
| rsp_illegal | output | 1 | Access must raise illegal-instruction |
| rsp_rdata | output | XLEN | Value before the access, zero when illegal or not owned |
| rsp_wstrb | output | SEL_COUNT*5 | One-hot strobe of the target that was written |

## Verification
Every result of this block appears in the single cycle after the edge that captures the request: the response flags, the data and the strobe all come out of one register stage. A select update made by one request is visible to the request in the following cycle. The driver pushes one expected item for each request at the falling edge where it drives that request. The monitor pops and compares an item only at a falling edge where a response is present, so each comparison lands exactly one cycle after its request. Requests are issued back to back, so the one-cycle pairing is exercised without idle gaps, and a final check confirms that no expected item is left unanswered.

// File: rtl/csr_iw_pkg.sv
package csr_iw_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SET   = 2'd2,
    OP_CLEAR = 2'd3
  } csr_op_e;

  localparam logic [1:0]  PRIV_MACHINE = 2'b11;
  localparam logic [11:0] ADDR_SELECT  = 12'h350;
  localparam int          WIN_COUNT    = 5;
  localparam int          WIN_IDX_W    = $clog2(WIN_COUNT);

endpackage

// File: rtl/csr_iw_addr_decode.sv
module csr_iw_addr_decode
  import csr_iw_pkg::*;
(
  input  logic [11:0]          addr,
  output logic                 is_select,
  output logic                 is_window,
  output logic [WIN_IDX_W-1:0] win_idx
);

  // Window numbers skip 0x354, which belongs to another register.
  localparam logic [11:0] WIN_ADDR [WIN_COUNT] = '{
    12'h351, 12'h352, 12'h353, 12'h355, 12'h356
  };

  logic [WIN_COUNT-1:0] win_match;

  for (genvar w = 0; w < WIN_COUNT; w++) begin : g_win
    assign win_match[w] = (addr == WIN_ADDR[w]);
  end

  assign is_select = (addr == ADDR_SELECT);
  assign is_window = |win_match;

  always_comb begin
    win_idx = '0;
    for (int w = 0; w < WIN_COUNT; w++) begin
      if (win_match[w]) win_idx = WIN_IDX_W'(w);
    end
  end

endmodule

// File: rtl/csr_iw_update.sv
module csr_iw_update
  import csr_iw_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [1:0]      op,
  input  logic [XLEN-1:0] old_val,
  input  logic [XLEN-1:0] operand,
  output logic [XLEN-1:0] new_val,
  output logic            changes
);

  always_comb begin
    new_val = old_val;
    changes = 1'b0;
    unique case (csr_op_e'(op))
      OP_READ: begin
        new_val = old_val;
        changes = 1'b0;
      end
      OP_WRITE: begin
        new_val = operand;
        changes = 1'b1;
      end
      OP_SET: begin
        new_val = old_val | operand;
        changes = |operand;
      end
      OP_CLEAR: begin
        new_val = old_val & ~operand;
        changes = |operand;
      end
      default: begin
        new_val = old_val;
        changes = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/csr_iw_target_bank.sv
module csr_iw_target_bank #(
  parameter int XLEN    = 32,
  parameter int NUM_TGT = 20,
  localparam int IDX_W  = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [XLEN-1:0]  wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [XLEN-1:0]  rd_data
);

  logic [XLEN-1:0] store_q [NUM_TGT];
  logic [NUM_TGT-1:0] slot_en;

  for (genvar t = 0; t < NUM_TGT; t++) begin : g_slot
    assign slot_en[t] = wr_en && (wr_idx == IDX_W'(t));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        store_q[t] <= '0;
      end else if (slot_en[t]) begin
        store_q[t] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int t = 0; t < NUM_TGT; t++) begin
      if (rd_idx == IDX_W'(t)) rd_data = store_q[t];
    end
  end

endmodule

// File: rtl/csr_indirect_window.sv
module csr_indirect_window
  import csr_iw_pkg::*;
#(
  parameter int              XLEN      = 32,
  parameter int              SEL_COUNT = 4,
  parameter logic [XLEN-1:0] SEL_BASE  = 'h40
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           csr_valid,
  input  logic [11:0]                    csr_addr,
  input  logic [1:0]                     csr_op,
  input  logic [XLEN-1:0]                csr_wdata,
  input  logic [1:0]                     priv_lvl,
  output logic                           rsp_valid,
  output logic                           rsp_hit,
  output logic                           rsp_illegal,
  output logic [XLEN-1:0]                rsp_rdata,
  output logic [SEL_COUNT*WIN_COUNT-1:0] rsp_wstrb
);

  localparam int NUM_TGT   = SEL_COUNT * WIN_COUNT;
  localparam int TGT_IDX_W = (NUM_TGT > 1) ? $clog2(NUM_TGT) : 1;
  localparam int SEL_OFF_W = (SEL_COUNT > 1) ? $clog2(SEL_COUNT) : 1;

  // Decode
  logic                 is_select;
  logic                 is_window;
  logic [WIN_IDX_W-1:0] win_idx;

  csr_iw_addr_decode u_decode (
    .addr      (csr_addr),
    .is_select (is_select),
    .is_window (is_window),
    .win_idx   (win_idx)
  );

  // Select register and redirection
  logic [XLEN-1:0]      sel_q;
  logic [XLEN-1:0]      sel_n;
  logic                 sel_en;
  logic [XLEN-1:0]      sel_off;
  logic                 sel_impl;
  logic [TGT_IDX_W-1:0] tgt_idx;

  assign sel_off  = sel_q - SEL_BASE;
  assign sel_impl = (sel_q >= SEL_BASE) && (sel_off < XLEN'(SEL_COUNT));

  always_comb begin
    tgt_idx = TGT_IDX_W'(sel_off[SEL_OFF_W-1:0]) * TGT_IDX_W'(WIN_COUNT)
            + TGT_IDX_W'(win_idx);
  end

  // Target storage
  logic            bank_we;
  logic [XLEN-1:0] bank_rd;
  logic [XLEN-1:0] old_val;
  logic [XLEN-1:0] new_val;
  logic            changes;

  csr_iw_target_bank #(
    .XLEN    (XLEN),
    .NUM_TGT (NUM_TGT)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (bank_we),
    .wr_idx  (tgt_idx),
    .wr_data (new_val),
    .rd_idx  (tgt_idx),
    .rd_data (bank_rd)
  );

  assign old_val = is_select ? sel_q : bank_rd;

  csr_iw_update #(
    .XLEN (XLEN)
  ) u_update (
    .op      (csr_op),
    .old_val (old_val),
    .operand (csr_wdata),
    .new_val (new_val),
    .changes (changes)
  );

  // Access qualification
  logic owned;
  logic illegal;
  logic granted;

  assign owned   = is_select || is_window;
  assign illegal = csr_valid && owned &&
                   ((priv_lvl != PRIV_MACHINE) || (is_window && !sel_impl));
  assign granted = csr_valid && owned && !illegal;
  assign bank_we = granted && is_window && changes;

  always_comb begin
    sel_en = granted && is_select && changes;
    sel_n  = new_val;
  end

  // Response next state
  logic                 valid_n;
  logic                 hit_n;
  logic                 illegal_n;
  logic [XLEN-1:0]      rdata_n;
  logic [NUM_TGT-1:0]   wstrb_n;

  always_comb begin
    valid_n   = csr_valid;
    hit_n     = csr_valid && owned;
    illegal_n = illegal;
    rdata_n   = granted ? old_val : '0;
    wstrb_n   = bank_we ? (NUM_TGT'(1) << tgt_idx) : '0;
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= '0;
    end else if (sel_en) begin
      sel_q <= sel_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_hit     <= 1'b0;
      rsp_illegal <= 1'b0;
      rsp_rdata   <= '0;
      rsp_wstrb   <= '0;
    end else begin
      rsp_valid   <= valid_n;
      rsp_hit     <= hit_n;
      rsp_illegal <= illegal_n;
      rsp_rdata   <= rdata_n;
      rsp_wstrb   <= wstrb_n;
    end
  end

endmodule

// File: rtl/csr_iw_checker.sv
module csr_iw_checker #(
  parameter int XLEN    = 32,
  parameter int NUM_TGT = 20
) (
  input logic               clk,
  input logic               rst_n,
  input logic               csr_valid,
  input logic [11:0]        csr_addr,
  input logic [1:0]         csr_op,
  input logic [1:0]         priv_lvl,
  input logic               rsp_valid,
  input logic               rsp_hit,
  input logic               rsp_illegal,
  input logic [XLEN-1:0]    rsp_rdata,
  input logic [NUM_TGT-1:0] rsp_wstrb
);

  // R9
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csr_valid |=> rsp_valid);

  // R9
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_valid |=> !rsp_valid);

  // R5
  wstrb_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rsp_wstrb));

  // R5
  wstrb_needs_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_wstrb != '0) |-> (rsp_valid && rsp_hit));

  // R4
  read_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_valid && csr_op == 2'd0) |=> (rsp_wstrb == '0));

  // R6
  illegal_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_illegal |-> (rsp_hit && rsp_wstrb == '0 && rsp_rdata == '0));

  // R7
  lowpriv_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_valid && priv_lvl != 2'b11) |=> (rsp_wstrb == '0));

  // R8
  gap_addr_unowned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_valid && csr_addr == 12'h354) |=> (!rsp_hit && !rsp_illegal));

  // R8
  miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_hit) |-> (!rsp_illegal && rsp_wstrb == '0 && rsp_rdata == '0));

endmodule

bind csr_indirect_window csr_iw_checker #(
  .XLEN    (XLEN),
  .NUM_TGT (SEL_COUNT * csr_iw_pkg::WIN_COUNT)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .csr_valid   (csr_valid),
  .csr_addr    (csr_addr),
  .csr_op      (csr_op),
  .priv_lvl    (priv_lvl),
  .rsp_valid   (rsp_valid),
  .rsp_hit     (rsp_hit),
  .rsp_illegal (rsp_illegal),
  .rsp_rdata   (rsp_rdata),
  .rsp_wstrb   (rsp_wstrb)
);

// File: tb/csr_indirect_window_bench.sv
module csr_indirect_window_bench;

  localparam int CLK_PERIOD = 10;
  localparam int XLEN       = 32;
  localparam int SEL_COUNT  = 4;
  localparam int WINS       = 5;
  localparam int NUM_TGT    = SEL_COUNT * WINS;
  localparam logic [31:0] BASE = 32'h40;
  localparam logic [1:0] PM = 2'd3;
  localparam logic [1:0] OPR = 2'd0, OPW = 2'd1, OPS = 2'd2, OPC = 2'd3;

  logic               clk;
  logic               rst_n;
  logic               csr_valid;
  logic [11:0]        csr_addr;
  logic [1:0]         csr_op;
  logic [XLEN-1:0]    csr_wdata;
  logic [1:0]         priv_lvl;
  logic               rsp_valid;
  logic               rsp_hit;
  logic               rsp_illegal;
  logic [XLEN-1:0]    rsp_rdata;
  logic [NUM_TGT-1:0] rsp_wstrb;

  csr_indirect_window u_csr_indirect_window (
    .clk         (clk),
    .rst_n       (rst_n),
    .csr_valid   (csr_valid),
    .csr_addr    (csr_addr),
    .csr_op      (csr_op),
    .csr_wdata   (csr_wdata),
    .priv_lvl    (priv_lvl),
    .rsp_valid   (rsp_valid),
    .rsp_hit     (rsp_hit),
    .rsp_illegal (rsp_illegal),
    .rsp_rdata   (rsp_rdata),
    .rsp_wstrb   (rsp_wstrb)
  );

  typedef struct packed {
    logic               hit;
    logic               ill;
    logic [XLEN-1:0]    rdata;
    logic [NUM_TGT-1:0] wstrb;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  int    total = 0;
  int    bad   = 0;
  int    issued = 0;
  int    answered = 0;
  bit    done = 0;

  logic [XLEN-1:0] sel_m;
  logic [XLEN-1:0] tgt_m [NUM_TGT];

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic int win_of(input logic [11:0] a);
    case (a)
      12'h351: return 1;
      12'h352: return 2;
      12'h353: return 3;
      12'h355: return 4;
      12'h356: return 5;
      default: return 0;
    endcase
  endfunction

  function automatic logic [XLEN-1:0] apply(input logic [1:0] op,
      input logic [XLEN-1:0] o, input logic [XLEN-1:0] d);
    case (op)
      OPW:     return d;
      OPS:     return o | d;
      OPC:     return o & ~d;
      default: return o;
    endcase
  endfunction

  // Driver: drives one request at a falling edge and queues its expectation.
  task automatic issue(input logic [11:0] a, input logic [1:0] op,
      input logic [XLEN-1:0] d, input logic [1:0] p, input string tag);
    exp_t e;
    int   w;
    bit   eff;
    int   k;
    @(negedge clk);
    csr_valid = 1'b1;
    csr_addr  = a;
    csr_op    = op;
    csr_wdata = d;
    priv_lvl  = p;
    e   = '0;
    w   = win_of(a);
    eff = (op == OPW) || ((op == OPS || op == OPC) && d != '0);
    if (a == 12'h350 || w != 0) begin
      e.hit = 1'b1;
      if (p != PM) begin
        e.ill = 1'b1;
      end else if (a == 12'h350) begin
        e.rdata = sel_m;
        if (eff) sel_m = apply(op, sel_m, d);
      end else if (sel_m >= BASE && sel_m < BASE + SEL_COUNT) begin
        k = int'(sel_m - BASE) * WINS + (w - 1);
        e.rdata = tgt_m[k];
        if (eff) begin
          tgt_m[k] = apply(op, tgt_m[k], d);
          e.wstrb  = NUM_TGT'(1) << k;
        end
      end else begin
        e.ill = 1'b1;
      end
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
    issued++;
  endtask

  task automatic idle();
    @(negedge clk);
    csr_valid = 1'b0;
    csr_op    = OPR;
    csr_wdata = '0;
  endtask

  // Monitor: compares each response one cycle after its request.
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      exp_t  e;
      string t;
      answered++;
      total++;
      if (exp_q.size() == 0) begin
        bad++;
        $display("FAIL R9: response with no request pending, got hit=%b ill=%b expected none",
                 rsp_hit, rsp_illegal);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rsp_hit !== e.hit || rsp_illegal !== e.ill ||
            rsp_rdata !== e.rdata || rsp_wstrb !== e.wstrb) begin
          bad++;
          $display("FAIL %s: got hit=%b ill=%b rdata=%h wstrb=%h, expected hit=%b ill=%b rdata=%h wstrb=%h",
                   t, rsp_hit, rsp_illegal, rsp_rdata, rsp_wstrb,
                   e.hit, e.ill, e.rdata, e.wstrb);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: run did not finish, got hung, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    sel_m = '0;
    for (int i = 0; i < NUM_TGT; i++) tgt_m[i] = '0;
    rst_n     = 1'b0;
    csr_valid = 1'b0;
    csr_addr  = '0;
    csr_op    = OPR;
    csr_wdata = '0;
    priv_lvl  = PM;
    repeat (3) @(negedge clk);
    total++;
    if (rsp_valid !== 1'b0 || rsp_wstrb !== '0) begin
      bad++;
      $display("FAIL R1: during reset got valid=%b wstrb=%h, expected 0/0", rsp_valid, rsp_wstrb);
    end
    rst_n = 1'b1;
    idle();

    // R1: reset values visible through the normal interface
    issue(12'h350, OPR, 0, PM, "R1");
    issue(12'h351, OPR, 0, PM, "R6");
    // R2 then R9: select write immediately followed by an alias access
    issue(12'h350, OPW, 32'h40, PM, "R2");
    issue(12'h351, OPW, 32'hA5A5_0001, PM, "R9");
    issue(12'h352, OPR, 0, PM, "R1");
    issue(12'h350, OPR, 0, PM, "R2");
    // R3: every window
    issue(12'h352, OPW, 32'h1111_0002, PM, "R3");
    issue(12'h353, OPW, 32'h2222_0003, PM, "R3");
    issue(12'h355, OPW, 32'h3333_0004, PM, "R3");
    issue(12'h356, OPW, 32'h4444_0005, PM, "R3");
    issue(12'h351, OPR, 0, PM, "R3");
    issue(12'h352, OPR, 0, PM, "R3");
    issue(12'h353, OPR, 0, PM, "R3");
    issue(12'h355, OPR, 0, PM, "R3");
    issue(12'h356, OPR, 0, PM, "R3");
    // R8: not owned
    issue(12'h354, OPW, 32'hFFFF_FFFF, PM, "R8");
    issue(12'h354, OPR, 0, PM, "R8");
    issue(12'h34F, OPW, 32'hDEAD_BEEF, PM, "R8");
    issue(12'h357, OPW, 32'hDEAD_BEEF, PM, "R8");
    issue(12'h355, OPR, 0, PM, "R8");
    issue(12'h350, OPR, 0, PM, "R8");
    // R5 and R9: select change between accesses, highest target
    issue(12'h350, OPW, 32'h43, PM, "R9");
    issue(12'h356, OPW, 32'hCAFE_0019, PM, "R5");
    issue(12'h351, OPR, 0, PM, "R5");
    issue(12'h350, OPW, 32'h40, PM, "R9");
    issue(12'h356, OPR, 0, PM, "R9");
    // R4: set, clear, zero operands
    issue(12'h351, OPS, 32'h0000_00F0, PM, "R4");
    issue(12'h351, OPC, 32'h0000_0001, PM, "R4");
    issue(12'h351, OPS, 32'h0, PM, "R4");
    issue(12'h351, OPC, 32'h0, PM, "R4");
    issue(12'h351, OPR, 0, PM, "R4");
    issue(12'h351, OPW, 32'h0, PM, "R4");
    issue(12'h351, OPR, 0, PM, "R4");
    // R6: unimplemented select values
    issue(12'h350, OPW, 32'h44, PM, "R6");
    issue(12'h351, OPR, 0, PM, "R6");
    issue(12'h352, OPW, 32'h1234_5678, PM, "R6");
    issue(12'h350, OPW, 32'h3F, PM, "R6");
    issue(12'h353, OPS, 32'hFF, PM, "R6");
    issue(12'h350, OPW, 32'h351, PM, "R6");
    issue(12'h351, OPW, 32'h5555_5555, PM, "R6");
    // R7: lower privilege
    issue(12'h350, OPW, 32'h41, PM, "R7");
    issue(12'h350, OPW, 32'h40, 2'd1, "R7");
    issue(12'h351, OPW, 32'h7777_7777, 2'd0, "R7");
    issue(12'h352, OPS, 32'hFFFF_0000, 2'd2, "R7");
    issue(12'h350, OPR, 0, 2'd0, "R7");
    issue(12'h350, OPR, 0, PM, "R7");
    issue(12'h351, OPR, 0, PM, "R7");
    issue(12'h352, OPR, 0, PM, "R7");
    // R2: set and clear on the select register
    issue(12'h350, OPC, 32'h1, PM, "R2");
    issue(12'h350, OPS, 32'h2, PM, "R2");
    issue(12'h350, OPR, 0, PM, "R2");
    issue(12'h353, OPR, 0, PM, "R2");
    idle();
    idle();
    idle();

    total++;
    if (exp_q.size() != 0 || answered != issued) begin
      bad++;
      $display("FAIL R9: got %0d responses with %0d pending, expected %0d responses",
               answered, exp_q.size(), issued);
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule